// File: doc/BRIEF.md
# Power-Managed Mode Sequencer

This block decides when a small CPU core runs, idles or sleeps, and how it gets back to running. A sleep-instruction strobe taken while running parks the core. The idle-enable bit picks between two halted states. In idle the CPU clock stops and the peripherals stay clocked. In sleep both clocks stop. A two-bit clock-select field chooses between the internal oscillator (value 00) and the primary oscillator (any other value). The sequencer turns the primary oscillator on and off to match that choice, and it reports when the primary oscillator is stable.

While halted, the block waits for an enabled interrupt flag or a watchdog time-out. It then passes through an optional oscillator start-up wait and a fixed wake delay before the CPU clock returns. It raises a one-cycle vector strobe when an interrupt woke the core and the global interrupt enable is set. A watchdog time-out while the core runs becomes a reset request. The sleep and clear-watchdog instructions clear the watchdog. All pins are plain control and status levels or strobes. No data stream passes through the block, so it has no handshake.

Top module: `pms_sequencer`

## Requirements
- R1: While reset is low, and after reset from any state, the mode output is RUN (0). CPU and peripheral clock enables are 1. The primary oscillator enable, the oscillator-stable bit, the primary-source flag, the watchdog reset request and the vector strobe are all 0. Mode encoding: RUN 0, IDLE 1, SLEEP 2, WAKE_OST 3, WAKE_DELAY 4.
- R2: A sleep strobe in RUN with idle-enable set moves the mode to IDLE on the next clock. In that mode the CPU clock enable is 0 and the peripheral clock enable is 1.
- R3: A sleep strobe in RUN with idle-enable clear moves the mode to SLEEP on the next clock. In that mode both clock enables are 0 and the primary oscillator enable is 0.
- R4: In RUN the primary oscillator enable follows whether clock-select is nonzero. Sleep, or idle with clock-select 00, turns it off. Idle with clock-select nonzero keeps it on. The stable bit goes to 0 one cycle after the enable falls. After the enable rises, the stable bit goes to 1 after OST_CYCLES cycles, or after one cycle when the external-clock input is set.
- R5: A halted mode ends only on a flag whose enable bit is set, or on a watchdog time-out. Flags with a clear enable bit and sleep strobes have no effect while halted.
- R6: When no start-up wait is needed, the mode is WAKE_DELAY for exactly WAKE_DLY cycles. The CPU clock enable returns WAKE_DLY+1 cycles after the clock edge at which the wake cause is applied.
- R7: A start-up wait is needed when clock-select is nonzero, the primary oscillator is not stable and the external-clock input is clear. The CPU clock enable then returns OST_CYCLES+WAKE_DLY+2 cycles after the wake cause.
- R8: The vector strobe is 1 for exactly the first RUN cycle after a wake. It is set only when an interrupt caused the wake and the global interrupt enable was 1 at that moment.
- R9: A watchdog time-out in RUN sets the watchdog reset request for one cycle on the next clock. A time-out while halted wakes the core and raises no reset request.
- R10: A sleep strobe or a clear-watchdog strobe in RUN produces a one-cycle watchdog clear on the next clock.
- R11: The internal oscillator enable is 1 whenever the keep-internal input is 1. Otherwise it is 1 only outside SLEEP and while the CPU is not running from the primary source.
- R12: The primary-source flag rises one cycle after the oscillator-stable bit, while clock-select is nonzero outside SLEEP. It stays 0 until then, so the core runs from the internal oscillator after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_exec | input | 1 | Sleep instruction executed (strobe) |
| clrwdt_exec | input | 1 | Clear-watchdog instruction executed (strobe) |
| idle_en | input | 1 | 1 selects idle, 0 selects sleep |
| clk_sel | input | 2 | 00 internal oscillator, otherwise primary |
| ext_clk_mode | input | 1 | Primary source is an external clock (no start-up wait) |
| keep_int_osc | input | 1 | Watchdog or clock monitor needs the internal oscillator |
| irq_flag | input | N_IRQ | Interrupt flags |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out |
| mode_o | output | 3 | Current mode (encoding in R1) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| osc_stable | output | 1 | Primary oscillator stable |
| src_pri | output | 1 | Core is running from the primary source |
| int_osc_en | output | 1 | Internal oscillator enable |
| wdt_clear | output | 1 | Watchdog clear pulse |
| wdt_reset_req | output | 1 | Watchdog reset request pulse |
| vector_strobe | output | 1 | Branch-to-vector pulse on wake |

## Verification
The properties assume that the instruction strobes come from a running core. Strobes that arrive while halted must leave the mode alone. They also assume that clock-select and the external-clock input are held steady while the core is halted, because software cannot change them then. The bench changes those two inputs only in RUN and clears every interrupt flag before each sleep strobe. It also drives each wake cause only after the halted mode has been observed. Every wake therefore starts from a known state, and its latency can be counted exactly.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_SLEEP    = 3'd2,
    ST_WAKE_OST = 3'd3,
    ST_WAKE_DLY = 3'd4
  } pms_state_e;

  localparam logic [1:0] SEL_INTERNAL = 2'b00;
endpackage

// File: rtl/pms_wake_qual.sv
module pms_wake_qual #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_timeout,
  output logic             irq_wake,
  output logic             any_wake
);
  logic [N_IRQ-1:0] hit;

  // one qualifying gate per interrupt source
  for (genvar g = 0; g < N_IRQ; g++) begin : g_src
    assign hit[g] = irq_flag[g] & irq_en[g];
  end

  assign irq_wake = |hit;
  assign any_wake = irq_wake | wdt_timeout;
endmodule

// File: rtl/pms_osc_ctrl.sv
module pms_osc_ctrl #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pri_on,
  input  logic ext_clk,
  output logic osc_stable
);
  localparam int CW = $clog2(OST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      osc_stable <= 1'b0;
    end else if (!pri_on) begin
      cnt        <= '0;
      osc_stable <= 1'b0;
    end else if (ext_clk) begin
      osc_stable <= 1'b1;
    end else if (!osc_stable) begin
      cnt        <= cnt + CW'(1);
      osc_stable <= (cnt == CW'(OST_CYCLES - 1));
    end
  end
endmodule

// File: rtl/pms_delay_timer.sv
module pms_delay_timer #(
  parameter int DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(DLY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  assign done = run && (cnt == CW'(DLY - 1));
endmodule

// File: rtl/pms_sequencer.sv
module pms_sequencer
  import pms_pkg::*;
#(
  parameter int N_IRQ      = 8,
  parameter int WAKE_DLY   = 8,
  parameter int OST_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_exec,
  input  logic             clrwdt_exec,
  input  logic             idle_en,
  input  logic [1:0]       clk_sel,
  input  logic             ext_clk_mode,
  input  logic             keep_int_osc,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             wdt_timeout,
  output logic [2:0]       mode_o,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             pri_osc_en,
  output logic             osc_stable,
  output logic             src_pri,
  output logic             int_osc_en,
  output logic             wdt_clear,
  output logic             wdt_reset_req,
  output logic             vector_strobe
);
  pms_state_e state, state_nx;
  logic pri_q, pri_nx;
  logic src_q, branch_q, clr_q, rst_req_q, vec_q;
  logic irq_wake, any_wake, dly_done;
  logic pri_sel, halted, need_ost;

  pms_wake_qual #(.N_IRQ(N_IRQ)) u_wake (
    .irq_flag   (irq_flag),
    .irq_en     (irq_en),
    .wdt_timeout(wdt_timeout),
    .irq_wake   (irq_wake),
    .any_wake   (any_wake)
  );

  pms_osc_ctrl #(.OST_CYCLES(OST_CYCLES)) u_osc (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_on    (pri_q),
    .ext_clk   (ext_clk_mode),
    .osc_stable(osc_stable)
  );

  pms_delay_timer #(.DLY(WAKE_DLY)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == ST_WAKE_DLY),
    .done (dly_done)
  );

  assign pri_sel  = (clk_sel != SEL_INTERNAL);
  assign halted   = (state == ST_IDLE) || (state == ST_SLEEP);
  assign need_ost = pri_sel && !ext_clk_mode && !osc_stable;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:      if (sleep_exec) state_nx = idle_en ? ST_IDLE : ST_SLEEP;
      ST_IDLE,
      ST_SLEEP:    if (any_wake) state_nx = need_ost ? ST_WAKE_OST : ST_WAKE_DLY;
      ST_WAKE_OST: if (osc_stable || ext_clk_mode) state_nx = ST_WAKE_DLY;
      ST_WAKE_DLY: if (dly_done) state_nx = ST_RUN;
      default:     state_nx = ST_RUN;
    endcase
  end

  // primary oscillator: held while halted, follows the select elsewhere
  always_comb begin
    if (state == ST_RUN && sleep_exec) pri_nx = idle_en && pri_sel;
    else if (halted && !any_wake)      pri_nx = pri_q;
    else                               pri_nx = pri_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      pri_q     <= 1'b0;
      src_q     <= 1'b0;
      branch_q  <= 1'b0;
      clr_q     <= 1'b0;
      rst_req_q <= 1'b0;
      vec_q     <= 1'b0;
    end else begin
      state     <= state_nx;
      pri_q     <= pri_nx;
      src_q     <= (state != ST_SLEEP) && pri_q && osc_stable && pri_sel;
      if (halted && any_wake) branch_q <= irq_wake && gie;
      clr_q     <= (state == ST_RUN) && (sleep_exec || clrwdt_exec);
      rst_req_q <= (state == ST_RUN) && wdt_timeout;
      vec_q     <= dly_done && branch_q;
    end
  end

  assign mode_o        = state;
  assign cpu_clk_en    = (state == ST_RUN);
  assign per_clk_en    = (state != ST_SLEEP);
  assign pri_osc_en    = pri_q;
  assign src_pri       = src_q;
  assign int_osc_en    = keep_int_osc || ((state != ST_SLEEP) && !src_q);
  assign wdt_clear     = clr_q;
  assign wdt_reset_req = rst_req_q;
  assign vector_strobe = vec_q;
endmodule

// File: rtl/pms_sequencer_chk.sv
module pms_sequencer_chk
  import pms_pkg::*;
#(
  parameter int N_IRQ    = 8,
  parameter int WAKE_DLY = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_exec,
  input logic             idle_en,
  input logic [N_IRQ-1:0] irq_flag,
  input logic [N_IRQ-1:0] irq_en,
  input logic             wdt_timeout,
  input logic [2:0]       mode_o,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             pri_osc_en,
  input logic             osc_stable,
  input logic             wdt_reset_req,
  input logic             vector_strobe
);
  localparam int CW = $clog2(WAKE_DLY + 1) + 1;
  logic [CW-1:0] dly_cnt;
  logic [2:0]    prev_mode;
  logic          wake_in;

  assign wake_in = (|(irq_flag & irq_en)) || wdt_timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_cnt   <= '0;
      prev_mode <= 3'(ST_RUN);
    end else begin
      dly_cnt   <= (mode_o == 3'(ST_WAKE_DLY)) ? dly_cnt + CW'(1) : '0;
      prev_mode <= mode_o;
    end
  end

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'(ST_RUN) && sleep_exec && idle_en) |=> (mode_o == 3'(ST_IDLE) && !cpu_clk_en && per_clk_en));

  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'(ST_RUN) && sleep_exec && !idle_en) |=> (mode_o == 3'(ST_SLEEP) && !per_clk_en && !pri_osc_en));

  assert_osc_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_osc_en) |=> !osc_stable);

  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'(ST_IDLE) || mode_o == 3'(ST_SLEEP)) && !wake_in) |=> $stable(mode_o));

  assert_delay_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'(ST_WAKE_DLY)) |-> (dly_cnt < CW'(WAKE_DLY) && !cpu_clk_en));

  assert_delay_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'(ST_RUN) && prev_mode == 3'(ST_WAKE_DLY)) |-> (dly_cnt == CW'(WAKE_DLY)));

  assert_vector_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vector_strobe |-> (cpu_clk_en && prev_mode == 3'(ST_WAKE_DLY)));

  assert_no_reset_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 3'(ST_RUN)) |=> !wdt_reset_req);
endmodule

bind pms_sequencer pms_sequencer_chk #(.N_IRQ(N_IRQ), .WAKE_DLY(WAKE_DLY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_exec   (sleep_exec),
  .idle_en      (idle_en),
  .irq_flag     (irq_flag),
  .irq_en       (irq_en),
  .wdt_timeout  (wdt_timeout),
  .mode_o       (mode_o),
  .cpu_clk_en   (cpu_clk_en),
  .per_clk_en   (per_clk_en),
  .pri_osc_en   (pri_osc_en),
  .osc_stable   (osc_stable),
  .wdt_reset_req(wdt_reset_req),
  .vector_strobe(vector_strobe)
);

// File: tb/pms_sequencer_bench.sv
module pms_sequencer_bench;
  localparam int N_IRQ = 8;
  localparam int DLY   = 8;
  localparam int OST   = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_exec = 0, clrwdt_exec = 0, idle_en = 0, ext_clk_mode = 0, keep_int_osc = 0;
  logic gie = 0, wdt_timeout = 0;
  logic [1:0] clk_sel = 2'b00;
  logic [N_IRQ-1:0] irq_flag = '0, irq_en = '0;
  logic [2:0] mode_o;
  logic cpu_clk_en, per_clk_en, pri_osc_en, osc_stable, src_pri, int_osc_en;
  logic wdt_clear, wdt_reset_req, vector_strobe;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pms_sequencer #(.N_IRQ(N_IRQ), .WAKE_DLY(DLY), .OST_CYCLES(OST)) u_pms_sequencer (
    .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .clrwdt_exec(clrwdt_exec),
    .idle_en(idle_en), .clk_sel(clk_sel), .ext_clk_mode(ext_clk_mode),
    .keep_int_osc(keep_int_osc), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
    .wdt_timeout(wdt_timeout), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .pri_osc_en(pri_osc_en), .osc_stable(osc_stable),
    .src_pri(src_pri), .int_osc_en(int_osc_en), .wdt_clear(wdt_clear),
    .wdt_reset_req(wdt_reset_req), .vector_strobe(vector_strobe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // issue a sleep strobe for one cycle, sample after the edge
  task automatic do_sleep(input logic idle);
    idle_en = idle; sleep_exec = 1'b1;
    @(negedge clk);
    sleep_exec = 1'b0;
  endtask

  // count cycles until the CPU clock is back; wake pulses end after one cycle
  task automatic wait_run(output int n, output bit saw_rst);
    n = 0; saw_rst = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      n++;
      wdt_timeout = 1'b0;
      if (wdt_reset_req) saw_rst = 1;
      if (cpu_clk_en) break;
    end
  endtask

  task automatic t_reset;
    chk("R1", "mode", mode_o, 0);
    chk("R1", "cpu_clk_en", cpu_clk_en, 1);
    chk("R1", "per_clk_en", per_clk_en, 1);
    chk("R1", "pri_osc_en", pri_osc_en, 0);
    chk("R1", "osc_stable", osc_stable, 0);
    chk("R1", "src_pri", src_pri, 0);
    chk("R1", "wdt_reset_req", wdt_reset_req, 0);
    chk("R1", "vector_strobe", vector_strobe, 0);
  endtask

  task automatic t_wdt_in_run;
    wdt_timeout = 1'b1; @(negedge clk); wdt_timeout = 1'b0;
    chk("R9", "reset request in run", wdt_reset_req, 1);
    @(negedge clk);
    chk("R9", "reset request single", wdt_reset_req, 0);
    chk("R9", "mode stays run", mode_o, 0);
    clrwdt_exec = 1'b1; @(negedge clk); clrwdt_exec = 1'b0;
    chk("R10", "clear after clrwdt", wdt_clear, 1);
    @(negedge clk);
    chk("R10", "clear single", wdt_clear, 0);
  endtask

  task automatic t_idle_irq_wake;
    int n; bit sr;
    clk_sel = 2'b00; gie = 1'b1;
    do_sleep(1'b1);
    chk("R2", "mode idle", mode_o, 1);
    chk("R2", "cpu off", cpu_clk_en, 0);
    chk("R2", "per on", per_clk_en, 1);
    chk("R10", "clear after sleep", wdt_clear, 1);
    irq_flag[1] = 1'b1; sleep_exec = 1'b1;
    tick(1); sleep_exec = 1'b0;
    tick(4);
    chk("R5", "disabled flag ignored", mode_o, 1);
    chk("R5", "cpu still off", cpu_clk_en, 0);
    irq_en[1] = 1'b1;
    wait_run(n, sr);
    chk("R6", "wake latency", n, DLY + 1);
    chk("R8", "vector with gie", vector_strobe, 1);
    irq_flag = '0; irq_en = '0;
    @(negedge clk);
    chk("R8", "vector single", vector_strobe, 0);
  endtask

  task automatic t_sleep_wdt_wake;
    int n; bit sr;
    keep_int_osc = 1'b0; gie = 1'b1;
    do_sleep(1'b0);
    chk("R3", "mode sleep", mode_o, 2);
    chk("R3", "per off", per_clk_en, 0);
    chk("R11", "int osc off in sleep", int_osc_en, 0);
    keep_int_osc = 1'b1; @(negedge clk);
    chk("R11", "int osc kept", int_osc_en, 1);
    wdt_timeout = 1'b1;
    wait_run(n, sr);
    chk("R9", "timeout wakes", n, DLY + 1);
    chk("R9", "no reset request when halted", sr, 0);
    chk("R8", "no vector on watchdog wake", vector_strobe, 0);
    keep_int_osc = 1'b0;
  endtask

  task automatic t_primary_ost;
    int n; bit sr;
    clk_sel = 2'b01; ext_clk_mode = 1'b0; gie = 1'b0;
    @(negedge clk);
    chk("R4", "primary on in run", pri_osc_en, 1);
    tick(500);
    chk("R4", "not yet stable", osc_stable, 0);
    chk("R12", "still internal", src_pri, 0);
    tick(OST + 10 - 500);
    chk("R4", "stable after wait", osc_stable, 1);
    chk("R12", "primary source", src_pri, 1);
    chk("R11", "int osc off on primary", int_osc_en, 0);
    do_sleep(1'b0);
    chk("R3", "primary off in sleep", pri_osc_en, 0);
    @(negedge clk);
    chk("R4", "stable drops", osc_stable, 0);
    irq_en[3] = 1'b1; irq_flag[3] = 1'b1;
    wait_run(n, sr);
    chk("R7", "wake with start-up wait", n, OST + DLY + 2);
    chk("R8", "no vector without gie", vector_strobe, 0);
    irq_flag = '0; irq_en = '0;
    tick(2);
  endtask

  task automatic t_ext_clock;
    int n; bit sr;
    ext_clk_mode = 1'b1;
    do_sleep(1'b0);
    @(negedge clk);
    chk("R4", "ext stable drops in sleep", osc_stable, 0);
    irq_en[0] = 1'b1; irq_flag[0] = 1'b1;
    wait_run(n, sr);
    chk("R7", "external clock skips wait", n, DLY + 1);
    chk("R4", "external clock stable", osc_stable, 1);
    irq_flag = '0; irq_en = '0; ext_clk_mode = 1'b0;
    tick(2);
  endtask

  task automatic t_primary_idle;
    int n; bit sr;
    gie = 1'b1;
    do_sleep(1'b1);
    tick(3);
    chk("R4", "primary kept in idle", pri_osc_en, 1);
    chk("R4", "stable kept in idle", osc_stable, 1);
    irq_en[7] = 1'b1; irq_flag[7] = 1'b1;
    wait_run(n, sr);
    chk("R6", "primary idle skips wait", n, DLY + 1);
    chk("R8", "vector from primary idle", vector_strobe, 1);
    irq_flag = '0; irq_en = '0;
    tick(1);
  endtask

  task automatic t_internal_switch;
    clk_sel = 2'b00; @(negedge clk);
    chk("R4", "primary off on internal select", pri_osc_en, 0);
    @(negedge clk);
    chk("R4", "stable off", osc_stable, 0);
    chk("R12", "back to internal", src_pri, 0);
  endtask

  task automatic t_reset_in_sleep;
    clk_sel = 2'b01; tick(OST + 5);
    do_sleep(1'b0);
    chk("R3", "sleep before reset", mode_o, 2);
    rst_n = 1'b0; @(negedge clk);
    t_reset;
    rst_n = 1'b1; tick(2);
    chk("R12", "internal after reset", src_pri, 0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report;
  end

  initial begin
    tick(3);
    t_reset;
    rst_n = 1'b1;
    tick(2);
    t_reset;
    t_wdt_in_run;
    t_idle_irq_wake;
    t_sleep_wdt_wake;
    t_primary_ost;
    t_ext_clock;
    t_primary_idle;
    t_internal_switch;
    t_reset_in_sleep;
    report;
  end
endmodule